// File: doc/BRIEF.md
# Conversion-Complete Interrupt Router

This block turns per-slot conversion events from a sixteen-slot sampling sequencer into a small set of interrupt lines, nine by default. Each line is programmed with an 8-bit setup byte. The byte picks which slot the line listens to, whether the line is armed, and whether the line fires on every event or waits until software acknowledges the previous one. Every line keeps a sticky pending flag and a sticky overrun flag. Software clears each one by writing a one to its bit in a clear register.

One global timing bit decides which strobe from the sequencer counts as the event for all lines. With the bit low, the event is the strobe marking the start of a slot's conversion. With the bit high, the event is the strobe the sequencer raises one cycle before that slot's result is latched. Each interrupt output is a registered one-cycle pulse. The pending and overrun vectors are also brought out as ports.

Top module: `adc_eoc_irq`

## Requirements
- R1: Setup byte bits 4:0 select the source slot (0 to 15). A line reacts only to an event on its selected slot. Codes 16 to 31 select no slot.
- R2: Setup byte bit 5 arms the line. An unarmed line produces no pulse and sets neither its pending flag nor its overrun flag.
- R3: With setup byte bit 6 low (hold-off mode), an armed line produces no pulse on an event while its pending flag is already set.
- R4: With setup byte bit 6 high (continuous mode), an armed line pulses on every event of its slot, whatever the state of its pending flag.
- R5: An event on an armed line sets its pending flag. The flag stays set until software writes 1 to that line's bit at address 2. If a set and a clear arrive in the same cycle, the set wins.
- R6: An event on an armed line whose pending flag is already set sets that line's overrun flag, in either mode. Writing 1 to the line's bit at address 4 clears the overrun flag, and a same-cycle set wins over the clear.
- R7: Control register bit 0 (address 0) selects the event. When it is 0, the conversion-start strobe is the event. When it is 1, the pre-latch strobe is the event. The strobe not selected is ignored.
- R8: A strobe sampled at a clock edge appears as `irq` high for exactly the following cycle. The pending flag is visible in that same cycle.
- R9: Register map: address 0 is the control register, 1 is pending (read), 2 is pending-clear (write), 3 is overrun (read), 4 is overrun-clear (write), and 8+n is line n's setup byte. All state resets to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| soc_strb | input | 16 | Per-slot conversion-start strobes |
| pre_latch_strb | input | 16 | Per-slot strobes, one cycle before the result latches |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 16 | Combinational read data |
| irq | output | 9 | One-cycle interrupt pulses, one per line |
| flag | output | 9 | Pending flags |
| ovf | output | 9 | Overrun flags |

## Verification
The bench pulses every slot at once to a line whose source code is out of range. A decoder that only looks at the low index bits would fire that line. It repeats events on a line in hold-off mode: a design that ignores the mode bit pulses a second time, and one that drops the overrun bit leaves it clear. It drives a clear write in the same cycle as an event. If the clear wins, the pending or overrun flag reads back low. It drives the strobe that is not selected by the timing bit, to catch a design that ORs the two strobes instead of choosing one.

// File: rtl/adc_eoc_irq.sv
module adc_eoc_irq #(
  parameter int NUM_LINES = 9,
  parameter int NUM_SLOTS = 16,
  parameter int SEL_W     = 5,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] soc_strb,
  input  logic [NUM_SLOTS-1:0] pre_latch_strb,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  output logic [NUM_LINES-1:0] irq,
  output logic [NUM_LINES-1:0] flag,
  output logic [NUM_LINES-1:0] ovf
);
  localparam int SLOT_W   = $clog2(NUM_SLOTS);
  localparam int A_CTRL   = 0;
  localparam int A_FLAG   = 1;
  localparam int A_FCLR   = 2;
  localparam int A_OVF    = 3;
  localparam int A_OCLR   = 4;
  localparam int A_CFG0   = 8;

  logic [NUM_LINES-1:0][7:0] cfg;
  logic                      late;
  logic [NUM_SLOTS-1:0]      evt;

  assign evt = late ? pre_latch_strb : soc_strb;

  wire fclr_wr = wr_en && (wr_addr == ADDR_W'(A_FCLR));
  wire oclr_wr = wr_en && (wr_addr == ADDR_W'(A_OCLR));

  always_ff @(posedge clk) begin
    if (!rst_n) late <= 1'b0;
    else if (wr_en && wr_addr == ADDR_W'(A_CTRL)) late <= wr_data[0];
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    wire [SEL_W-1:0] src  = cfg[i][SEL_W-1:0];
    wire             en   = cfg[i][5];
    wire             cont = cfg[i][6];
    wire             hit  = en && (src[SEL_W-1:SLOT_W] == '0) && evt[src[SLOT_W-1:0]];
    wire             fclr = fclr_wr && wr_data[i];
    wire             oclr = oclr_wr && wr_data[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg[i]  <= '0;
        irq[i]  <= 1'b0;
        flag[i] <= 1'b0;
        ovf[i]  <= 1'b0;
      end else begin
        if (wr_en && wr_addr == ADDR_W'(A_CFG0 + i)) cfg[i] <= wr_data[7:0];
        irq[i]  <= hit && (cont || !flag[i]);
        flag[i] <= hit || (flag[i] && !fclr);
        ovf[i]  <= (hit && flag[i]) || (ovf[i] && !oclr);
      end
    end

    AST_PULSE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> flag[i]); // R8
    AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !irq[i]); // R2
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && !cont) |=> !irq[i]); // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && !fclr) |=> flag[i]); // R5
    AST_OVF_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf[i]) |-> $past(flag[i])); // R6
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_W'(A_CTRL): rd_data = DATA_W'(late);
      ADDR_W'(A_FLAG): rd_data = DATA_W'(flag);
      ADDR_W'(A_OVF):  rd_data = DATA_W'(ovf);
      default: begin
        for (int k = 0; k < NUM_LINES; k++)
          if (rd_addr == ADDR_W'(A_CFG0 + k)) rd_data = DATA_W'(cfg[k]);
      end
    endcase
  end
endmodule

// File: tb/test_adc_eoc_irq.sv
module test_adc_eoc_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] soc_strb = '0, pre_latch_strb = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [8:0]  irq, flag, ovf;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  adc_eoc_irq i_adc_eoc_irq (
    .clk(clk), .rst_n(rst_n), .soc_strb(soc_strb), .pre_latch_strb(pre_latch_strb),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq), .flag(flag), .ovf(ovf));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); rd_addr = a; #1 d = rd_data;
  endtask

  task automatic ev(input logic [15:0] s, input logic [15:0] p, output logic [8:0] got);
    @(negedge clk); soc_strb = s; pre_latch_strb = p;
    @(posedge clk); #1 got = irq;
    @(negedge clk); soc_strb = '0; pre_latch_strb = '0;
  endtask

  task automatic clear_all;
    wr(5'd2, 16'h01FF); wr(5'd4, 16'h01FF);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    chk("R9 irq reset", irq, 0); chk("R9 flag reset", flag, 0); chk("R9 ovf reset", ovf, 0);
    rd(5'd8, d); chk("R9 cfg reset", d, 0);
    rd(5'd0, d); chk("R9 ctrl reset", d, 0);
  endtask

  task automatic t_source;
    logic [8:0] g; logic [15:0] d;
    wr(5'd8, 16'h0023); wr(5'd9, 16'h0034);
    rd(5'd8, d); chk("R9 cfg readback", d, 16'h0023);
    ev(16'hFFFF, 16'h0, g); chk("R1 code 20 selects nothing", g[1], 0);
    chk("R1 code 20 no flag", flag[1], 0);
    clear_all;
    ev(16'h0004, 16'h0, g); chk("R1 other slot ignored", g[0], 0);
    chk("R1 other slot no flag", flag[0], 0);
    ev(16'h0008, 16'h0, g); chk("R1 selected slot fires", g[0], 1);
    chk("R8 flag with pulse", flag[0], 1);
    @(posedge clk); #1 chk("R8 pulse one cycle", irq[0], 0);
    rd(5'd1, d); chk("R9 flag readback", d[0], 1);
    wr(5'd2, 16'h0001); chk("R5 W1C clears flag", flag[0], 0);
  endtask

  task automatic t_disable;
    logic [8:0] g;
    wr(5'd10, 16'h0005);
    ev(16'h0020, 16'h0, g); chk("R2 disarmed no pulse", g[2], 0);
    ev(16'h0020, 16'h0, g);
    chk("R2 disarmed no flag", flag[2], 0); chk("R2 disarmed no ovf", ovf[2], 0);
  endtask

  task automatic t_holdoff;
    logic [8:0] g;
    wr(5'd11, 16'h0027);
    ev(16'h0080, 16'h0, g); chk("R3 first pulse", g[3], 1);
    ev(16'h0080, 16'h0, g); chk("R3 held off", g[3], 0);
    chk("R6 overrun set", ovf[3], 1); chk("R5 flag kept", flag[3], 1);
    wr(5'd4, 16'h0008); chk("R6 overrun W1C", ovf[3], 0);
    wr(5'd2, 16'h0008);
    ev(16'h0080, 16'h0, g); chk("R3 re-fires after clear", g[3], 1);
    clear_all;
  endtask

  task automatic t_cont;
    logic [8:0] g;
    wr(5'd12, 16'h0068);
    ev(16'h0100, 16'h0, g); chk("R4 pulse 1", g[4], 1);
    ev(16'h0100, 16'h0, g); chk("R4 pulse 2", g[4], 1);
    chk("R6 overrun in continuous", ovf[4], 1);
    ev(16'h0100, 16'h0, g); chk("R4 pulse 3", g[4], 1);
    clear_all;
  endtask

  task automatic t_set_wins;
    wr(5'd13, 16'h0029);
    @(negedge clk); soc_strb = 16'h0200; wr_en = 1'b1; wr_addr = 5'd2; wr_data = 16'h0020;
    @(negedge clk); soc_strb = '0; wr_en = 1'b0;
    chk("R5 set beats clear", flag[5], 1);
    @(negedge clk); soc_strb = 16'h0200; wr_en = 1'b1; wr_addr = 5'd4; wr_data = 16'h0020;
    @(negedge clk); soc_strb = '0; wr_en = 1'b0;
    chk("R6 set beats clear", ovf[5], 1);
    clear_all;
  endtask

  task automatic t_position;
    logic [8:0] g; logic [15:0] d;
    wr(5'd14, 16'h002A); wr(5'd0, 16'h0001);
    rd(5'd0, d); chk("R9 ctrl readback", d, 1);
    ev(16'h0400, 16'h0, g); chk("R7 start ignored when late", g[6], 0);
    chk("R7 start ignored no flag", flag[6], 0);
    ev(16'h0, 16'h0400, g); chk("R7 pre-latch fires", g[6], 1);
    clear_all; wr(5'd0, 16'h0000);
    ev(16'h0, 16'h0400, g); chk("R7 pre-latch ignored when early", g[6], 0);
    chk("R7 pre-latch ignored no flag", flag[6], 0);
    ev(16'h0400, 16'h0, g); chk("R7 start fires", g[6], 1);
    clear_all;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset; t_source; t_disable; t_holdoff; t_cont; t_set_wins; t_position;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done"); end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule